// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block produces the control waveform that reads bytes out of a one-time-programmable fuse array. A one-cycle start request carries a first byte address and a byte count. The sequencer first puts the array into read mode. It then reads the bytes one after another at consecutive addresses. For each byte it runs four timed phases in order: present the address, let it settle, raise the strobe, then hold with the strobe low. The low eight bits of the array's data word are captured at the end of each strobe. Each captured byte leaves the block as a one-cycle valid pulse with its data.

When the last byte is done, the array control pins return to the standby pattern and a one-cycle done pulse is raised. Every phase length is counted in clock cycles. The lengths come from `CYCLES_PER_US`, so one build can target any clock frequency. With the defaults each timed phase lasts two microseconds. The address is a 10-bit field, because the control word decodes it from bit 6 to bit 15. It wraps modulo 1024.

Top module: `fuse_read_seq`

## Requirements
- R1: While reset is held and while idle, the pins show the standby pattern: `fuse_sel_o`=1, `fuse_prog_en_o`=1, `fuse_rd_mode_o`=0, `fuse_strobe_o`=0, `fuse_addr_o`=0. Also `busy_o`, `byte_vld_o` and `done_o` are 0.
- R2: An accepted start first drives `fuse_sel_o`=1 with `fuse_rd_mode_o`=0 and `fuse_prog_en_o`=0 for `CS_ONLY_CYC` cycles. Then `fuse_rd_mode_o` and `fuse_prog_en_o` rise together with `fuse_sel_o`=0, and they stay that way until completion. The first strobe rises at least 2·T cycles after that, where T = 2·`CYCLES_PER_US`.
- R3: For each byte, `fuse_addr_o` holds its value for at least T cycles before the strobe rises, and it does not change while the strobe is high.
- R4: The strobe stays high for at least T cycles. Between two strobe pulses of one run it stays low for at least 2·T cycles. The strobe is high only when `fuse_rd_mode_o`=1.
- R5: `byte_o` equals bits [7:0] of `fuse_dout_i` as sampled in the last strobe-high cycle. `byte_vld_o` is high for one cycle, in the cycle in which the strobe falls. Bits above 7 are discarded.
- R6: A run of N bytes starting at address A delivers exactly N bytes, for addresses A, A+1, …, A+N−1 modulo 1024, in that order.
- R7: After the last byte, `done_o` pulses for one cycle. In that same cycle the pins are back to the standby pattern and `busy_o` is 0.
- R8: A start request while `busy_o`=1 is ignored. The run in progress keeps its addresses and count, and no new read-mode entry begins.
- R9: A start with a count of 0 while idle raises `done_o` in the next cycle. It produces no strobe pulse and leaves the pins in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| start_addr_i | input | 10 | First byte address |
| byte_cnt_i | input | 8 | Number of bytes to read |
| fuse_dout_i | input | 32 | Data word from the fuse array |
| fuse_sel_o | output | 1 | Array select level |
| fuse_rd_mode_o | output | 1 | Read-mode (load) level |
| fuse_prog_en_o | output | 1 | Program-enable level |
| fuse_strobe_o | output | 1 | Read strobe |
| fuse_addr_o | output | 10 | Byte address field (control bits 15:6) |
| busy_o | output | 1 | Sequence in progress |
| byte_vld_o | output | 1 | Captured byte valid, one cycle |
| byte_o | output | 8 | Captured byte |
| done_o | output | 1 | Sequence complete, one cycle |

## Verification
The properties assume three things about the inputs. First, `start_addr_i` and `byte_cnt_i` are valid in the cycle in which `start_i` is high. Second, `start_i` is a level sampled on each rising edge. Third, `fuse_dout_i` carries a meaningful value only while the strobe is high. The stimulus changes every input only on falling clock edges and holds a start request for exactly one cycle. Its fuse model returns a known per-address pattern only while the strobe and read mode are both high, and zero at all other times.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CSEL,
      ST_SETTLE,
      ST_ADDR,
      ST_STROBE,
      ST_HOLD
   } seq_st_e;

   typedef struct packed {
      logic sel;
      logic rd_mode;
      logic prog_en;
      logic strobe;
   } fuse_pins_t;

   localparam fuse_pins_t PINS_STANDBY = '{sel: 1'b1, rd_mode: 1'b0, prog_en: 1'b1, strobe: 1'b0};

endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
   parameter int TMR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] len_i,
   output logic             expire_o
);
   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= len_i - 1'b1;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/fuse_pin_map.sv
module fuse_pin_map
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  seq_st_e           st_i,
   input  logic [ADDR_W-1:0] addr_i,
   output fuse_pins_t        pins_o,
   output logic [ADDR_W-1:0] addr_o
);
   always_comb begin
      pins_o = PINS_STANDBY;
      addr_o = '0;
      unique case (st_i)
         ST_IDLE: ;
         ST_CSEL:   pins_o = '{sel: 1'b1, rd_mode: 1'b0, prog_en: 1'b0, strobe: 1'b0};
         ST_SETTLE: pins_o = '{sel: 1'b0, rd_mode: 1'b1, prog_en: 1'b1, strobe: 1'b0};
         ST_ADDR, ST_HOLD: begin
            pins_o = '{sel: 1'b0, rd_mode: 1'b1, prog_en: 1'b1, strobe: 1'b0};
            addr_o = addr_i;
         end
         ST_STROBE: begin
            pins_o = '{sel: 1'b0, rd_mode: 1'b1, prog_en: 1'b1, strobe: 1'b1};
            addr_o = addr_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/fuse_byte_capture.sv
module fuse_byte_capture #(
   parameter int DOUT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [DOUT_W-1:0] dout_i,
   output logic              vld_o,
   output logic [7:0]        byte_o
);
   logic [7:0] low_byte;

   generate
      if (DOUT_W == 8) begin : g_exact
         assign low_byte = dout_i;
      end else begin : g_slice
         logic [DOUT_W-9:0] unused_hi;
         assign unused_hi = dout_i[DOUT_W-1:8];
         assign low_byte  = dout_i[7:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         byte_o <= '0;
      end else begin
         vld_o <= take_i;
         if (take_i) byte_o <= low_byte;
      end
   end
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
   import fuse_rd_pkg::*;
#(
   parameter int CYCLES_PER_US = 50,
   parameter int PHASE_US      = 2,
   parameter int CS_ONLY_CYC   = 1,
   parameter int ADDR_LSB      = 6,
   parameter int ADDR_MSB      = 15,
   parameter int CNT_W         = 8,
   parameter int DOUT_W        = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [ADDR_MSB-ADDR_LSB:0]   start_addr_i,
   input  logic [CNT_W-1:0]             byte_cnt_i,
   input  logic [DOUT_W-1:0]            fuse_dout_i,
   output logic                         fuse_sel_o,
   output logic                         fuse_rd_mode_o,
   output logic                         fuse_prog_en_o,
   output logic                         fuse_strobe_o,
   output logic [ADDR_MSB-ADDR_LSB:0]   fuse_addr_o,
   output logic                         busy_o,
   output logic                         byte_vld_o,
   output logic [7:0]                   byte_o,
   output logic                         done_o
);
   localparam int ADDR_W  = ADDR_MSB - ADDR_LSB + 1;
   localparam int PH_CYC  = CYCLES_PER_US * PHASE_US;
   localparam int MAX_CYC = (PH_CYC > CS_ONLY_CYC) ? PH_CYC : CS_ONLY_CYC;
   localparam int TMR_W   = $clog2(MAX_CYC + 1);

   generate
      if (CYCLES_PER_US < 1 || PHASE_US < 1) begin : g_bad_rate
         $error("fuse_read_seq: phase length must be at least one cycle");
      end
      if (CS_ONLY_CYC < 1) begin : g_bad_cs
         $error("fuse_read_seq: CS_ONLY_CYC must be at least 1");
      end
      if (ADDR_MSB < ADDR_LSB) begin : g_bad_field
         $error("fuse_read_seq: empty address field");
      end
      if (DOUT_W < 8 || CNT_W < 1) begin : g_bad_width
         $error("fuse_read_seq: data word below 8 bits or empty count");
      end
   endgenerate

   seq_st_e           st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  remain_q;
   logic              done_q;
   logic              adv, take, expire, last_byte, accept, zero_req;
   logic [TMR_W-1:0]  len_d;
   fuse_pins_t        pins;

   assign accept    = (st_q == ST_IDLE) && start_i;
   assign zero_req  = accept && (byte_cnt_i == '0);
   assign last_byte = (remain_q == CNT_W'(1));

   always_comb begin
      st_d = st_q;
      take = 1'b0;
      unique case (st_q)
         ST_IDLE:   if (accept && !zero_req) st_d = ST_CSEL;
         ST_CSEL:   if (expire) st_d = ST_SETTLE;
         ST_SETTLE: if (expire) st_d = ST_ADDR;
         ST_ADDR:   if (expire) st_d = ST_STROBE;
         ST_STROBE: if (expire) begin st_d = ST_HOLD; take = 1'b1; end
         ST_HOLD:   if (expire) st_d = last_byte ? ST_IDLE : ST_ADDR;
         default:   st_d = ST_IDLE;
      endcase
      adv   = (st_d != st_q) && (st_d != ST_IDLE);
      len_d = (st_d == ST_CSEL) ? TMR_W'(CS_ONLY_CYC) : TMR_W'(PH_CYC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         addr_q   <= '0;
         remain_q <= '0;
         done_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= zero_req || ((st_q == ST_HOLD) && expire && last_byte);
         if (accept) begin
            addr_q   <= start_addr_i;
            remain_q <= byte_cnt_i;
         end else if ((st_q == ST_HOLD) && expire && !last_byte) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
         end
      end
   end

   fuse_phase_timer #(.TMR_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (adv),
      .len_i    (len_d),
      .expire_o (expire)
   );

   fuse_pin_map #(.ADDR_W(ADDR_W)) u_pins (
      .st_i   (st_q),
      .addr_i (addr_q),
      .pins_o (pins),
      .addr_o (fuse_addr_o)
   );

   fuse_byte_capture #(.DOUT_W(DOUT_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .dout_i (fuse_dout_i),
      .vld_o  (byte_vld_o),
      .byte_o (byte_o)
   );

   assign fuse_sel_o     = pins.sel;
   assign fuse_rd_mode_o = pins.rd_mode;
   assign fuse_prog_en_o = pins.prog_en;
   assign fuse_strobe_o  = pins.strobe;
   assign busy_o         = (st_q != ST_IDLE);
   assign done_o         = done_q;

   // R2: read mode is entered only from the select-only step
   p_entry_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fuse_rd_mode_o) |-> $past(fuse_sel_o && !fuse_prog_en_o) && fuse_prog_en_o && !fuse_sel_o);

   // R3: address frozen while strobe is high
   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_strobe_o && $past(fuse_strobe_o)) |-> $stable(fuse_addr_o));

   // R4: strobe only inside read mode
   p_strobe_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_strobe_o |-> (fuse_rd_mode_o && fuse_prog_en_o && !fuse_sel_o));

   // R5: captured byte appears as the strobe falls
   p_vld_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> (!fuse_strobe_o && $past(fuse_strobe_o)));

   // R7: completion leaves the pins in standby
   p_done_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (fuse_sel_o && fuse_prog_en_o && !fuse_rd_mode_o && !fuse_strobe_o
                  && fuse_addr_o == '0 && !busy_o));

   // R8: the select-only step never starts from a busy sequence
   p_entry_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_sel_o && !fuse_prog_en_o && !$past(fuse_sel_o && !fuse_prog_en_o)) |-> !$past(busy_o));

   // R9: zero-length request finishes next cycle without a strobe
   p_zero_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && byte_cnt_i == '0) |=> (done_o && !busy_o && !fuse_strobe_o));
endmodule

// File: tb/fuse_read_seq_bench.sv
module fuse_read_seq_bench;
   localparam int CPU = 3;
   localparam int T   = 2 * CPU;
   localparam int NV  = 6;
   // {start address (10b), byte count (8b)}
   localparam logic [17:0] VEC [NV] = '{
      {10'd0,    8'd1},
      {10'd5,    8'd3},
      {10'd1021, 8'd5},
      {10'd100,  8'd2},
      {10'd512,  8'd4},
      {10'd255,  8'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [9:0]  start_addr = '0;
   logic [7:0]  byte_cnt = '0;
   logic [31:0] fuse_dout;
   logic        sel, rd_mode, prog_en, strobe, busy, vld, done;
   logic [9:0]  addr;
   logic [7:0]  rbyte;

   int checks = 0;
   int bad = 0;
   int n_rise = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] pat(input logic [9:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd37;
      return m ^ {6'b0, a[9:8]} ^ 8'hC3;
   endfunction

   assign fuse_dout = (strobe && rd_mode) ? {24'h5A3C96, pat(addr)} : 32'h0;

   fuse_read_seq #(.CYCLES_PER_US(CPU)) u_fuse_read_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
      .byte_cnt_i(byte_cnt), .fuse_dout_i(fuse_dout),
      .fuse_sel_o(sel), .fuse_rd_mode_o(rd_mode), .fuse_prog_en_o(prog_en),
      .fuse_strobe_o(strobe), .fuse_addr_o(addr), .busy_o(busy),
      .byte_vld_o(vld), .byte_o(rbyte), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit standby();
      return sel && prog_en && !rd_mode && !strobe && addr == 10'd0;
   endfunction

   // pin-order and phase-length monitor (R2, R3, R4)
   logic       p_strobe = 0, p_rd = 0, p_sel = 0, p_pe = 0, first_pend = 0, seen_fall = 0;
   logic [9:0] p_addr = '0;
   int since_rd = 0, addr_age = 0, hi_len = 0, lo_len = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         addr_age = (addr != p_addr) ? 0 : addr_age + 1;
         if (rd_mode && !p_rd) begin
            chk(p_sel && !p_pe && !sel && prog_en, "R2 entry order", {p_sel, p_pe}, 2);
            since_rd = 0; first_pend = 1; seen_fall = 0;
         end else since_rd++;
         if (strobe && !p_strobe) begin
            n_rise++;
            chk(addr_age >= T, "R3 address setup", addr_age, T);
            if (first_pend) chk(since_rd >= 2 * T, "R2 settle before first strobe", since_rd, 2 * T);
            if (seen_fall) chk(lo_len >= 2 * T, "R4 strobe low gap", lo_len, 2 * T);
            first_pend = 0; hi_len = 1;
         end else if (strobe) begin
            hi_len++;
            if (addr != p_addr) chk(0, "R3 address moved under strobe", addr, p_addr);
         end
         if (!strobe && p_strobe) begin
            chk(hi_len >= T, "R4 strobe width", hi_len, T);
            seen_fall = 1; lo_len = 1;
         end else if (!strobe) lo_len++;
         if (strobe && !rd_mode) chk(0, "R4 strobe outside read mode", 0, 1);
      end
      p_strobe = strobe; p_rd = rd_mode; p_sel = sel; p_pe = prog_en; p_addr = addr;
   end

   task automatic run(input logic [9:0] a, input int n, input bit inject);
      int idx = 0;
      bit got = 0;
      @(negedge clk);
      start_addr = a; byte_cnt = 8'(n); start = 1;
      @(negedge clk);
      start = 0;
      chk(sel && !rd_mode && !prog_en && busy, "R2 select-only step", {sel, rd_mode, prog_en}, 4);
      for (int c = 0; c < 4000 && !got; c++) begin
         if (inject && c == 10) begin
            start = 1; start_addr = a + 10'd300; byte_cnt = 8'd7;
         end else start = 0;
         @(negedge clk);
         if (vld) begin
            chk(idx < n, "R6 byte count", idx + 1, n);
            chk(rbyte == pat(a + 10'(idx)), inject ? "R8 run kept" : "R5 R6 byte data",
                rbyte, pat(a + 10'(idx)));
            idx++;
         end
         if (done) begin
            got = 1;
            chk(standby() && !busy, "R7 standby at done", {sel, rd_mode, prog_en, strobe}, 10);
         end
      end
      start = 0;
      chk(got, "R7 done seen", got, 1);
      chk(idx == n, inject ? "R8 count kept" : "R6 bytes delivered", idx, n);
      @(negedge clk);
      chk(!done && !busy && standby(), "R7 done one cycle", done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      int r0;
      repeat (3) @(negedge clk);
      chk(standby() && !busy && !vld && !done, "R1 reset state", {sel, prog_en, rd_mode, strobe}, 12);
      rst_n = 1;
      @(negedge clk);
      chk(standby() && !busy, "R1 idle state", {sel, prog_en, rd_mode, strobe}, 12);

      for (int v = 0; v < NV; v++) run(VEC[v][17:8], int'(VEC[v][7:0]), 0);

      // R8: start while busy is ignored
      run(10'd40, 3, 1);

      // R9: zero count
      r0 = n_rise;
      @(negedge clk);
      start_addr = 10'd7; byte_cnt = 8'd0; start = 1;
      @(negedge clk);
      start = 0;
      chk(done && !busy && standby(), "R9 zero count done", done, 1);
      @(negedge clk);
      chk(!done && !busy && standby(), "R9 zero count single pulse", done, 0);
      repeat (4) @(negedge clk);
      chk(n_rise == r0, "R9 no strobe", n_rise - r0, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule